// File: doc/BRIEF.md
# Delta-Panel Scan Timing Generator

This block produces every logic-level drive signal for a small active-matrix display whose row and column drivers are shift registers built into the glass. It runs from one master clock and builds each signal from a column counter, a row counter and a horizontal clock phase counter. The outputs are a start pulse for the column register and a complementary two-phase column clock. For the rows it gives a start pulse, a row shift clock and a gate enable. It also drives the two scan-direction levels, a widescreen blanking pulse, an active-low power-save level and a per-row polarity flag that steers an external video inverter.

Line length, clock half period, start-pulse position, delta-row offset, rows per field, blanking depth, enable-drop period and the mode bits all arrive as register inputs. A frame-sync pulse restarts all counters. A field also ends by itself after its last row. Settings are copied into a working set only at one of these two field boundaries, so a field never mixes old and new settings.

Top module: `lcd_scan_timer`

## Requirements
- R1: A `frameSync` pulse restarts the timing in any cycle, including mid-line. The row counter, column counter and clock phase return to zero, and the next field begins with the new settings.
- R2: `hck1` and `hck2` are never equal. With `rgt` high, `hck1` is high for the first `cfgHalfClks` master clocks of each row and then alternates every `cfgHalfClks` clocks. Each row therefore carries `cfgLineClks / (2*cfgHalfClks)` rising edges of `hck1`.
- R3: With `rgt` low, the two clock phases swap: `hck1` takes the waveform that `hck2` has in right scan, and `hck2` takes that of `hck1`.
- R4: `hst` is high for `2*cfgHalfClks` clocks. On even rows it starts at column position `cfgHstPos`. On odd rows it starts at `cfgHstPos + cfgDeltaClks`, which is the 1.5-dot delta shift when that value is half a clock period.
- R5: `vck` changes level once per row, at column position `cfgLineClks/2`. A field of N rows therefore has N transitions, and `vck` is low after a restart.
- R6: `vst` is high for the whole of row 0 of each field and low for all other rows. This places half a row of setup and half a row of hold around the `vck` edge in that row.
- R7: `vidInv` is 1 on odd rows and 0 on even rows, so it toggles every row.
- R8: With `cfgDropEvery` = 0, `en` stays high. With `cfgDropEvery` = N > 0, `en` is low for the whole of rows N-1, 2N-1, and so on within each field, counting from row 0.
- R9: With `cfgWide` = 1, `blk` is high on the first `cfgBlkLines` rows and the last `cfgBlkLines` rows of the field. With `cfgWide` = 0, `blk` stays low.
- R10: `stbN` is the inverse of the latched `cfgSleep`. `rgt` and `dwn` show the latched `cfgRightScan` and `cfgDownScan`.
- R11: Changes to the configuration inputs during a field have no effect until the next field boundary. They take effect on row 0, when `vst` is high.
- R12: While `rstN` is low, the outputs are: `hck1`=1, `hck2`=0, `en`=1, `rgt`=1, `dwn`=1, and all other outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rstN | input | 1 | synchronous active-low reset |
| frameSync | input | 1 | field restart pulse |
| cfgLineClks | input | 12 | master clocks per row |
| cfgHalfClks | input | 6 | master clocks per column clock half period |
| cfgHstPos | input | 12 | column start position on even rows |
| cfgDeltaClks | input | 12 | extra start delay on odd rows |
| cfgFieldLines | input | 10 | rows per field |
| cfgBlkLines | input | 10 | blanked rows at top and at bottom in wide mode |
| cfgDropEvery | input | 10 | enable-drop period in rows, 0 = off |
| cfgRightScan | input | 1 | 1 = right scan, 0 = left scan |
| cfgDownScan | input | 1 | 1 = top to bottom, 0 = bottom to top |
| cfgWide | input | 1 | 1 = widescreen blanking on |
| cfgSleep | input | 1 | 1 = request power save |
| hst | output | 1 | column start pulse |
| hck1 | output | 1 | column clock phase one |
| hck2 | output | 1 | column clock phase two |
| vst | output | 1 | row start pulse |
| vck | output | 1 | row shift clock |
| en | output | 1 | gate enable |
| blk | output | 1 | top/bottom blanking pulse |
| stbN | output | 1 | power save, active low |
| rgt | output | 1 | horizontal direction level |
| dwn | output | 1 | vertical direction level |
| vidInv | output | 1 | per-row video polarity flag |

## Verification
The hardest case to reach is a configuration change in the middle of a field that must stay hidden until the field wraps by itself, with no sync pulse. The stimulus starts a field and flips the scan direction and widescreen mode during row 2. It then samples `rgt` and `blk` in the last cycle of row 5, where both must still show the old values, and again in the first cycle after the wrap, where both must show the new values. A second delicate case is a restart in mid-line. There the free-running timing is interrupted at an arbitrary column, and the first row after the sync is compared cycle by cycle against the model.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
  localparam int CLK_W  = 12;
  localparam int HALF_W = 6;
  localparam int LINE_W = 10;

  typedef struct packed {
    logic [CLK_W-1:0]  lineClks;
    logic [HALF_W-1:0] halfClks;
    logic [CLK_W-1:0]  hstPos;
    logic [CLK_W-1:0]  deltaClks;
    logic [LINE_W-1:0] fieldLines;
    logic [LINE_W-1:0] blkLines;
    logic [LINE_W-1:0] dropEvery;
    logic              rightScan;
    logic              downScan;
    logic              wide;
    logic              sleep;
  } scanCfg_t;

  typedef struct packed {
    logic restart;
    logic hckPhase;
    logic hstOn;
    logic vckToggle;
    logic vstOn;
    logic lineOdd;
    logic enOff;
    logic blkOn;
    logic rightScan;
    logic downScan;
    logic sleep;
  } scanStrobe_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
`timescale 1ns/1ps
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSync,
  input  scanCfg_t    cfgIn,
  output scanStrobe_t stb
);
  localparam int EXT_W = CLK_W + 2;

  scanCfg_t          cfgAct;
  logic [CLK_W-1:0]  pix;
  logic [LINE_W-1:0] line;
  logic [HALF_W-1:0] phaseCnt;
  logic              phaseBit;
  logic [LINE_W-1:0] dropCnt;
  logic              restartQ;

  logic lineEnd, fieldEnd, phaseEnd, dropWrap;
  logic [EXT_W-1:0] hstStart, hstStop, pixExt;

  always_comb begin
    lineEnd  = ({1'b0, pix} + (CLK_W+1)'(1)) >= {1'b0, cfgAct.lineClks};
    fieldEnd = lineEnd && (({1'b0, line} + (LINE_W+1)'(1)) >= {1'b0, cfgAct.fieldLines});
    phaseEnd = ({1'b0, phaseCnt} + (HALF_W+1)'(1)) >= {1'b0, cfgAct.halfClks};
    dropWrap = ({1'b0, dropCnt} + (LINE_W+1)'(1)) >= {1'b0, cfgAct.dropEvery};
  end

  // counters; configuration is copied only at a field boundary (R11)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgAct           <= '0;
      cfgAct.rightScan <= 1'b1;
      cfgAct.downScan  <= 1'b1;
      cfgAct.sleep     <= 1'b1;
      pix      <= '0;
      line     <= '0;
      phaseCnt <= '0;
      phaseBit <= 1'b0;
      dropCnt  <= '0;
      restartQ <= 1'b0;
    end else if (frameSync) begin   // R1 restart
      cfgAct   <= cfgIn;
      pix      <= '0;
      line     <= '0;
      phaseCnt <= '0;
      phaseBit <= 1'b0;
      dropCnt  <= '0;
      restartQ <= 1'b1;
    end else begin
      restartQ <= 1'b0;
      if (lineEnd) begin
        pix      <= '0;
        phaseCnt <= '0;
        phaseBit <= 1'b0;
        if (fieldEnd) begin
          line    <= '0;
          dropCnt <= '0;
          cfgAct  <= cfgIn;
        end else begin
          line    <= line + LINE_W'(1);
          dropCnt <= dropWrap ? '0 : dropCnt + LINE_W'(1);
        end
      end else begin
        pix <= pix + CLK_W'(1);
        if (phaseEnd) begin
          phaseCnt <= '0;
          phaseBit <= ~phaseBit;
        end else begin
          phaseCnt <= phaseCnt + HALF_W'(1);
        end
      end
    end
  end

  // strobe decode toward the datapath
  always_comb begin
    pixExt   = {2'b00, pix};
    hstStart = {2'b00, cfgAct.hstPos} + (line[0] ? {2'b00, cfgAct.deltaClks} : '0);
    hstStop  = hstStart + {{(EXT_W-HALF_W-1){1'b0}}, cfgAct.halfClks, 1'b0};
    stb.restart   = restartQ;
    stb.hckPhase  = phaseBit;
    stb.hstOn     = (pixExt >= hstStart) && (pixExt < hstStop);        // R4
    stb.vckToggle = (pix == (cfgAct.lineClks >> 1));                    // R5
    stb.vstOn     = (line == '0);                                       // R6
    stb.lineOdd   = line[0];                                            // R7
    stb.enOff     = (cfgAct.dropEvery != '0) &&
                    (dropCnt == cfgAct.dropEvery - LINE_W'(1));         // R8
    stb.blkOn     = cfgAct.wide &&
                    ((line < cfgAct.blkLines) ||
                     (({1'b0, line} + {1'b0, cfgAct.blkLines}) >= {1'b0, cfgAct.fieldLines})); // R9
    stb.rightScan = cfgAct.rightScan;
    stb.downScan  = cfgAct.downScan;
    stb.sleep     = cfgAct.sleep;
  end
endmodule

// File: rtl/lcd_scan_dp.sv
`timescale 1ns/1ps
module lcd_scan_dp
  import lcd_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  scanStrobe_t stb,
  output logic        hst,
  output logic        hck1,
  output logic        hck2,
  output logic        vst,
  output logic        vck,
  output logic        en,
  output logic        blk,
  output logic        stbN,
  output logic        rgt,
  output logic        dwn,
  output logic        vidInv
);
  always_ff @(posedge clk) begin
    if (!rstN) begin   // R12
      hst    <= 1'b0;
      hck1   <= 1'b1;
      hck2   <= 1'b0;
      vst    <= 1'b0;
      vck    <= 1'b0;
      en     <= 1'b1;
      blk    <= 1'b0;
      stbN   <= 1'b0;
      rgt    <= 1'b1;
      dwn    <= 1'b1;
      vidInv <= 1'b0;
    end else begin
      // R2/R3: phase swap for mirrored scan
      hck1   <= stb.rightScan ? ~stb.hckPhase : stb.hckPhase;
      hck2   <= stb.rightScan ? stb.hckPhase : ~stb.hckPhase;
      hst    <= stb.hstOn;
      vst    <= stb.vstOn;
      vck    <= stb.restart ? 1'b0 : (vck ^ stb.vckToggle);
      en     <= ~stb.enOff;
      blk    <= stb.blkOn;
      stbN   <= ~stb.sleep;
      rgt    <= stb.rightScan;
      dwn    <= stb.downScan;
      vidInv <= stb.lineOdd;
    end
  end
endmodule

// File: rtl/lcd_scan_timer.sv
`timescale 1ns/1ps
module lcd_scan_timer
  import lcd_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic [CLK_W-1:0]  cfgLineClks,
  input  logic [HALF_W-1:0] cfgHalfClks,
  input  logic [CLK_W-1:0]  cfgHstPos,
  input  logic [CLK_W-1:0]  cfgDeltaClks,
  input  logic [LINE_W-1:0] cfgFieldLines,
  input  logic [LINE_W-1:0] cfgBlkLines,
  input  logic [LINE_W-1:0] cfgDropEvery,
  input  logic              cfgRightScan,
  input  logic              cfgDownScan,
  input  logic              cfgWide,
  input  logic              cfgSleep,
  output logic              hst,
  output logic              hck1,
  output logic              hck2,
  output logic              vst,
  output logic              vck,
  output logic              en,
  output logic              blk,
  output logic              stbN,
  output logic              rgt,
  output logic              dwn,
  output logic              vidInv
);
  scanCfg_t    cfgIn;
  scanStrobe_t stb;

  always_comb begin
    cfgIn.lineClks   = cfgLineClks;
    cfgIn.halfClks   = cfgHalfClks;
    cfgIn.hstPos     = cfgHstPos;
    cfgIn.deltaClks  = cfgDeltaClks;
    cfgIn.fieldLines = cfgFieldLines;
    cfgIn.blkLines   = cfgBlkLines;
    cfgIn.dropEvery  = cfgDropEvery;
    cfgIn.rightScan  = cfgRightScan;
    cfgIn.downScan   = cfgDownScan;
    cfgIn.wide       = cfgWide;
    cfgIn.sleep      = cfgSleep;
  end

  lcd_scan_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .cfgIn(cfgIn), .stb(stb)
  );

  lcd_scan_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hst(hst), .hck1(hck1), .hck2(hck2), .vst(vst), .vck(vck), .en(en),
    .blk(blk), .stbN(stbN), .rgt(rgt), .dwn(dwn), .vidInv(vidInv)
  );
endmodule

// File: rtl/lcd_scan_checker.sv
`timescale 1ns/1ps
module lcd_scan_checker (
  input logic clk,
  input logic rstN,
  input logic frameSync,
  input logic hst,
  input logic hck1,
  input logic hck2,
  input logic vst,
  input logic vck,
  input logic rgt,
  input logic dwn,
  input logic vidInv
);
  assert_hck_complement_R2: assert property (@(posedge clk) disable iff (!rstN)
    hck1 != hck2);

  assert_hst_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hst) && !frameSync) |=> hst);

  assert_vck_mid_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(vck) && !$past(frameSync)) |-> $stable(vidInv));

  assert_dir_at_boundary_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rgt) || !$stable(dwn)) |-> vst);
endmodule

bind lcd_scan_timer lcd_scan_checker i_lcd_scan_checker (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .hst(hst), .hck1(hck1),
  .hck2(hck2), .vst(vst), .vck(vck), .rgt(rgt), .dwn(dwn), .vidInv(vidInv)
);

// File: tb/test_lcd_scan_timer.sv
`timescale 1ns/1ps
module test_lcd_scan_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameSync = 1'b0;
  logic [11:0] cLine = 12'd40;
  logic [5:0]  cHalf = 6'd2;
  logic [11:0] cHstPos = 12'd4;
  logic [11:0] cDelta = 12'd2;
  logic [9:0]  cField = 10'd6;
  logic [9:0]  cBlk = 10'd1;
  logic [9:0]  cDrop = 10'd0;
  logic cRight = 1'b1, cDown = 1'b1, cWide = 1'b0, cSleep = 1'b0;
  logic hst, hck1, hck2, vst, vck, en, blk, stbN, rgt, dwn, vidInv;
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  lcd_scan_timer i_lcd_scan_timer (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .cfgLineClks(cLine), .cfgHalfClks(cHalf), .cfgHstPos(cHstPos),
    .cfgDeltaClks(cDelta), .cfgFieldLines(cField), .cfgBlkLines(cBlk),
    .cfgDropEvery(cDrop), .cfgRightScan(cRight), .cfgDownScan(cDown),
    .cfgWide(cWide), .cfgSleep(cSleep),
    .hst(hst), .hck1(hck1), .hck2(hck2), .vst(vst), .vck(vck), .en(en),
    .blk(blk), .stbN(stbN), .rgt(rgt), .dwn(dwn), .vidInv(vidInv)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applySync();
    @(negedge clk) frameSync = 1'b1;
    @(posedge clk);
    @(negedge clk) frameSync = 1'b0;
  endtask

  // one field-aligned window compared cycle by cycle against the model
  task automatic runScan(input int cycles, input bit checkRestart);
    int mHck = 0, mHst = 0, mVck = 0, mVst = 0, mInv = 0, mEn = 0, mBlk = 0;
    int mStat = 0, mFirst = 0, rises = 0, vckEdges = 0;
    logic prevHck1 = 1'b0, prevVck = 1'b0, expVck = 1'b0;
    int ln = int'(cLine), hf = int'(cHalf), fl = int'(cField);
    applySync();
    for (int k = 0; k < cycles; k++) begin
      int lineIdx = (k / ln) % fl;
      int p = k % ln;
      int hStart = int'(cHstPos) + ((lineIdx % 2 == 1) ? int'(cDelta) : 0);
      bit ph = ((p / hf) % 2) == 1;
      bit eH1 = cRight ? !ph : ph;
      bit eHst = (p >= hStart) && (p < hStart + 2 * hf);
      bit eEn = !((cDrop != 0) && (lineIdx % int'(cDrop) == int'(cDrop) - 1));
      bit eBlk = cWide && ((lineIdx < int'(cBlk)) || (lineIdx >= fl - int'(cBlk)));
      int bad = 0;
      if (p == ln / 2) expVck = ~expVck;
      @(posedge clk);
      @(negedge clk);
      if (hck1 !== eH1 || hck2 !== !eH1) begin mHck++; bad++; end
      if (hst !== eHst) begin mHst++; bad++; end
      if (vck !== expVck) begin mVck++; bad++; end
      if (vst !== (lineIdx == 0)) begin mVst++; bad++; end
      if (vidInv !== (lineIdx % 2 == 1)) begin mInv++; bad++; end
      if (en !== eEn) begin mEn++; bad++; end
      if (blk !== eBlk) begin mBlk++; bad++; end
      if (stbN !== !cSleep || rgt !== cRight || dwn !== cDown) begin mStat++; bad++; end
      if (k < ln && bad != 0) mFirst++;
      if (k > 0 && hck1 && !prevHck1) rises++;
      if (k > 0 && vck !== prevVck) vckEdges++;
      prevHck1 = hck1;
      prevVck = vck;
    end
    if (cRight) begin
      check(mHck == 0, "R2", "hck waveform mismatches", mHck, 0);
      check(rises == (cycles / ln) * (ln / (2 * hf)) - 1, "R2", "hck1 rising edges",
            rises, (cycles / ln) * (ln / (2 * hf)) - 1);
    end else begin
      check(mHck == 0, "R3", "swapped hck mismatches", mHck, 0);
    end
    check(mHst == 0, "R4", "hst mismatches", mHst, 0);
    check(mVck == 0, "R5", "vck level mismatches", mVck, 0);
    check(vckEdges == cycles / ln, "R5", "vck transitions", vckEdges, cycles / ln);
    check(mVst == 0, "R6", "vst mismatches", mVst, 0);
    check(mInv == 0, "R7", "vidInv mismatches", mInv, 0);
    check(mEn == 0, "R8", "en mismatches", mEn, 0);
    check(mBlk == 0, "R9", "blk mismatches", mBlk, 0);
    check(mStat == 0, "R10", "stbN/rgt/dwn mismatches", mStat, 0);
    if (checkRestart)
      check(mFirst == 0, "R1", "first row after mid-line sync mismatches", mFirst, 0);
  endtask

  task automatic testReset();
    logic [10:0] got;
    repeat (4) @(posedge clk);
    @(negedge clk);
    got = {hck1, hck2, hst, vst, vck, en, blk, stbN, vidInv, rgt, dwn};
    check(got == 11'b10000100011, "R12", "reset output vector", int'(got), 11'b10000100011);
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic testRightNarrow();
    cLine = 12'd40; cHalf = 6'd2; cHstPos = 12'd4; cDelta = 12'd2; cField = 10'd6;
    cBlk = 10'd1; cDrop = 10'd0; cRight = 1'b1; cDown = 1'b1; cWide = 1'b0; cSleep = 1'b0;
    runScan(480, 1'b0);
  endtask

  task automatic testLeftWide();
    cLine = 12'd40; cHalf = 6'd2; cHstPos = 12'd6; cDelta = 12'd2; cField = 10'd6;
    cBlk = 10'd1; cDrop = 10'd3; cRight = 1'b0; cDown = 1'b0; cWide = 1'b1; cSleep = 1'b1;
    runScan(480, 1'b0);
  endtask

  // R11: mid-field change must wait for the field wrap at cycle 240
  task automatic testDeferredCfg();
    logic rgtOld = 1'b0, rgtNew = 1'b1, blkOld = 1'b1, blkNew = 1'b0;
    cLine = 12'd40; cHalf = 6'd2; cHstPos = 12'd4; cDelta = 12'd2; cField = 10'd6;
    cBlk = 10'd1; cDrop = 10'd0; cRight = 1'b1; cDown = 1'b1; cWide = 1'b0; cSleep = 1'b0;
    applySync();
    for (int k = 0; k < 300; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 100) begin cRight = 1'b0; cWide = 1'b1; end
      if (k == 239) begin rgtOld = rgt; blkOld = blk; end
      if (k == 240) begin rgtNew = rgt; blkNew = blk; end
    end
    check(rgtOld == 1'b1, "R11", "rgt before field wrap", int'(rgtOld), 1);
    check(blkOld == 1'b0, "R11", "blk before field wrap", int'(blkOld), 0);
    check(rgtNew == 1'b0, "R11", "rgt after field wrap", int'(rgtNew), 0);
    check(blkNew == 1'b1, "R11", "blk after field wrap", int'(blkNew), 1);
  endtask

  // R1: restart from an arbitrary column with a new geometry
  task automatic testMidLineSync();
    repeat (57) @(posedge clk);
    cLine = 12'd24; cHalf = 6'd3; cHstPos = 12'd2; cDelta = 12'd3; cField = 10'd4;
    cBlk = 10'd1; cDrop = 10'd2; cRight = 1'b1; cDown = 1'b0; cWide = 1'b1; cSleep = 1'b0;
    runScan(192, 1'b1);
  endtask

  initial begin
    #500000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    testRightNarrow();
    testLeftWide();
    testDeferredCfg();
    testMidLineSync();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule